// File: doc/BRIEF.md
# Parallel Dual-Mode Transmit FFE Datapath

This block is the digital front end of a serial transmitter. On every clock it accepts a wide word that carries sixteen symbols side by side, together with a mode flag that picks two-level (NRZ) or four-level (PAM4) signalling. Each symbol becomes a signed level. The block then computes an eight-tap feed-forward equalizer over the symbol stream, and for each lane it returns a saturated 7-bit unsigned code for a DAC. A serializer further down the chain takes these sixteen codes per clock and plays them out one after another, lane 0 first.

The eight tap weights are signed 8-bit values. Software loads them into a shadow bank through a small write port, and a single commit pulse moves all of them into the active bank at once. The block keeps the last seven symbols of the previous word, so taps that reach back past lane 0 pick up those symbols. When the mode flips, that history is wiped, and the lanes that would otherwise read stale symbols are parked at the mid code.

Top module: `ffe_tx_dp`

## Requirements
- R1: In NRZ mode (`mode_pam4`=0), lane k takes its symbol from `in_data[k]`. A 0 maps to level -3 and a 1 maps to level +3.
- R2: In PAM4 mode (`mode_pam4`=1), lane k takes its symbol from `in_data[2k+1:2k]`, with bit 2k+1 as the MSB. The pairs 00, 01, 11 and 10 map to levels -3, -1, +1 and +3.
- R3: The raw sum for lane k is the sum over j = 0..7 of tap[j] × level(k−j). Lane 0 is the earliest symbol in a word. A negative index k−j selects lane 16+k−j of the previous valid word.
- R4: The raw sum is rounded by adding 4 and then shifting arithmetically right by 3, so exact halves round toward +infinity.
- R5: The rounded value is clamped to the range −64..+63. The output code is that value plus 64, written as a 7-bit unsigned number in `out_codes[7k+6:7k]`.
- R6: `out_valid` equals `in_valid` from three clocks earlier. The codes shown with it belong to that word.
- R7: A write (`cfg_we`) stores `cfg_wdata` into shadow tap `cfg_addr` and does not change any output until a commit.
- R8: After reset every active and shadow tap is 0. On a clock with `cfg_commit` high, the whole shadow bank, as it stood before that edge, becomes active. A word accepted on that same clock still uses the old taps, and later words use the new ones.
- R9: The first valid word after reset, and any valid word whose mode differs from the previous valid word, sees a history of zero levels. Lanes 0..6 of such a word output code 64.
- R10: The symbol history and the recorded mode advance only on cycles with `in_valid` high. Idle cycles between words do not change later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A symbol word is present this cycle |
| mode_pam4 | input | 1 | 0 = NRZ, 1 = PAM4 |
| in_data | input | 32 | Symbol bits; NRZ uses [15:0], PAM4 uses two bits per lane |
| cfg_we | input | 1 | Write strobe for the shadow tap bank |
| cfg_addr | input | 3 | Tap index to write; 0 is the main cursor |
| cfg_wdata | input | 8 | Two's-complement tap weight |
| cfg_commit | input | 1 | Copy the shadow bank to the active bank |
| out_valid | output | 1 | Codes on out_codes are valid |
| out_codes | output | 112 | Sixteen 7-bit DAC codes, lane k at bits [7k+6:7k] |

## Verification
The bench targets these corner cases:
- **History across words.** A tap-7-only setting puts a symbol in lane 9 of one word and expects it in lane 0 of the next. Idle cycles are then placed between the two words. A design that drops history, or shifts it on idle cycles, yields the opposite sign.
- **Rounding.** An exact half case (±1.5) catches a rounding step that truncates, or that rounds toward zero.
- **Saturation.** Full-scale sums at both ends catch a wrapped result.
- **Commit boundary.** A commit issued on the same clock as a word checks that the word keeps the old taps and the next word takes the new ones.
- **Mode flips.** NRZ→PAM4→NRZ flips check the mid-code parking of lanes 0..6 and the PAM4 Gray mapping. A misordered map returns the wrong code for the 01 and 10 pairs.

// File: rtl/ffe_pkg.sv
// Package: shared level type and the symbol-to-level mapping for both modes.
// Assumes levels fit in three signed bits (-3..+3).
package ffe_pkg;
    localparam int LVL_W = 3;

    typedef logic signed [LVL_W-1:0] level_t;

    // Map one symbol to its signed level; pam4=0 looks only at bits[0].
    function automatic level_t map_sym(input logic pam4, input logic [1:0] bits);
        level_t lv;
        if (!pam4) begin
            lv = bits[0] ? level_t'(3) : level_t'(-3);
        end else begin
            case (bits)
                2'b00:   lv = level_t'(-3);
                2'b01:   lv = level_t'(-1);
                2'b11:   lv = level_t'(1);
                default: lv = level_t'(3);
            endcase
        end
        return lv;
    endfunction
endpackage

// File: rtl/ffe_coef_bank.sv
// Module: two-bank tap storage. Writes land in the shadow bank; a commit
// copies the whole shadow bank into the active bank on one edge, so the
// multipliers never see a half-updated set. Assumes TAPS >= 2.
module ffe_coef_bank #(
    parameter int TAPS = 8,
    parameter int CW   = 8,
    localparam int AW  = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CW-1:0]            wr_data,
    input  logic                     commit,
    output logic [TAPS-1:0][CW-1:0]  taps_o
);
    logic [TAPS-1:0][CW-1:0] shadow_q;
    logic [TAPS-1:0][CW-1:0] active_q;

    // Shadow bank: one tap updated per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            shadow_q[wr_addr] <= wr_data;
        end
    end

    // Active bank: bulk copy from shadow on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (commit) begin
            active_q <= shadow_q;
        end
    end

    assign taps_o = active_q;

    // R7
    no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_q));

    // R8
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active_q == $past(shadow_q)));
endmodule

// File: rtl/ffe_sym_hist.sv
// Module: maps the incoming word to levels and keeps the last TAPS-1
// levels of the previous valid word. It presents an extended window:
// the history (oldest first), followed by the current word.
// A fresh word (first after reset or after a mode flip) sees a zero
// history, and fresh_o marks it. Assumes LANES >= TAPS-1.
module ffe_sym_hist
    import ffe_pkg::*;
#(
    parameter int LANES = 16,
    parameter int TAPS  = 8,
    localparam int HIST = TAPS - 1,
    localparam int EXT  = LANES + HIST
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         mode_pam4,
    input  logic [2*LANES-1:0]           in_data,
    output logic [EXT-1:0][LVL_W-1:0]    ext_o,
    output logic                         fresh_o
);
    logic [LANES-1:0][LVL_W-1:0] cur_lvl;
    logic [HIST-1:0][LVL_W-1:0]  hist_q;
    logic                        last_mode_q;
    logic                        fresh_q;
    logic                        clear;

    // Per-lane mapping; NRZ uses one bit per lane, PAM4 uses a pair.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            cur_lvl[k] = map_sym(mode_pam4,
                                 mode_pam4 ? in_data[2*k +: 2] : {1'b0, in_data[k]});
        end
    end

    assign clear   = fresh_q | (mode_pam4 != last_mode_q);
    assign fresh_o = clear;

    // Build the window: zeroed history on a fresh word, then the current lanes.
    always_comb begin
        for (int i = 0; i < HIST; i++) begin
            ext_o[i] = clear ? '0 : hist_q[i];
        end
        for (int k = 0; k < LANES; k++) begin
            ext_o[HIST + k] = cur_lvl[k];
        end
    end

    // Keep the tail of each valid word and the mode it was sent in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q      <= '0;
            last_mode_q <= 1'b0;
            fresh_q     <= 1'b1;
        end else if (in_valid) begin
            for (int i = 0; i < HIST; i++) begin
                hist_q[i] <= cur_lvl[LANES - HIST + i];
            end
            last_mode_q <= mode_pam4;
            fresh_q     <= 1'b0;
        end
    end

    // R10
    idle_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(hist_q) && $stable(last_mode_q)));
endmodule

// File: rtl/ffe_lane.sv
// Module: one output lane. It has three register stages:
// tap products, adder-tree sum, and round/saturate/offset.
// win_i[j] is the level j symbols before this lane's own symbol.
// hold_i parks the lane at the mid code.
module ffe_lane
    import ffe_pkg::*;
#(
    parameter int TAPS  = 8,
    parameter int CW    = 8,
    parameter int OW    = 7,
    parameter int SHIFT = 3,
    localparam int PW   = LVL_W + CW,
    localparam int SW   = PW + $clog2(TAPS) + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [TAPS-1:0][LVL_W-1:0]    win_i,
    input  logic [TAPS-1:0][CW-1:0]       taps_i,
    input  logic                          hold_i,
    output logic [OW-1:0]                 code_o
);
    localparam logic signed [SW-1:0] RND  = SW'(2 ** (SHIFT - 1));
    localparam logic signed [SW-1:0] MAXV = SW'(2 ** (OW - 1) - 1);
    localparam logic signed [SW-1:0] MINV = SW'(-(2 ** (OW - 1)));
    localparam logic signed [SW-1:0] SAT_HI_SUM = SW'((2 ** (OW - 1)) * (2 ** SHIFT) - 2 ** (SHIFT - 1) - 1);
    localparam logic [OW-1:0]        MID  = {1'b1, {(OW-1){1'b0}}};

    logic [TAPS-1:0][PW-1:0] prod_q;
    logic                    hold1_q, hold2_q;
    logic signed [SW-1:0]    tree_sum;
    logic signed [SW-1:0]    sum_q;
    logic signed [SW-1:0]    rnd_sum;
    logic signed [SW-1:0]    shifted;
    logic [OW-1:0]           sat_v;
    logic [OW-1:0]           code_q;

    // Stage 1: signed level times signed tap, one product per tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            hold1_q <= 1'b0;
        end else begin
            for (int j = 0; j < TAPS; j++) begin
                prod_q[j] <= PW'($signed(win_i[j])) * PW'($signed(taps_i[j]));
            end
            hold1_q <= hold_i;
        end
    end

    // Log-depth pairwise reduction of the products.
    always_comb begin : tree_reduce
        logic signed [SW-1:0] acc [TAPS];
        for (int j = 0; j < TAPS; j++) begin
            acc[j] = SW'($signed(prod_q[j]));
        end
        for (int span = 1; span < TAPS; span = span * 2) begin
            for (int j = 0; j + span < TAPS; j = j + 2 * span) begin
                acc[j] = acc[j] + acc[j + span];
            end
        end
        tree_sum = acc[0];
    end

    // Stage 2: register the tree result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            hold2_q <= 1'b0;
        end else begin
            sum_q   <= tree_sum;
            hold2_q <= hold1_q;
        end
    end

    // Round half up, shift, clamp to the signed output range.
    always_comb begin
        rnd_sum = sum_q + RND;
        shifted = rnd_sum >>> SHIFT;
        if (shifted > MAXV) begin
            sat_v = OW'(MAXV);
        end else if (shifted < MINV) begin
            sat_v = OW'(MINV);
        end else begin
            sat_v = OW'(shifted);
        end
    end

    // Stage 3: offset-binary code, or mid code while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= MID;
        end else begin
            code_q <= hold2_q ? MID : {~sat_v[OW-1], sat_v[OW-2:0]};
        end
    end

    assign code_o = code_q;

    // R5
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold2_q && (sum_q > SAT_HI_SUM)) |=> (code_o == {OW{1'b1}}));
endmodule

// File: rtl/ffe_tx_dp.sv
// Module: top of the parallel dual-mode transmit equalizer. It joins the
// symbol history, the tap banks and LANES output lanes, and delays the
// valid flag to match the three-stage lane pipeline.
// Assumes LANES >= TAPS-1, so only lanes 0..TAPS-2 read history.
module ffe_tx_dp
    import ffe_pkg::*;
#(
    parameter int LANES = 16,
    parameter int TAPS  = 8,
    parameter int CW    = 8,
    parameter int OW    = 7,
    parameter int SHIFT = 3,
    localparam int AW   = $clog2(TAPS),
    localparam int HIST = TAPS - 1,
    localparam int EXT  = LANES + HIST,
    localparam int LAT  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  mode_pam4,
    input  logic [2*LANES-1:0]    in_data,
    input  logic                  cfg_we,
    input  logic [AW-1:0]         cfg_addr,
    input  logic [CW-1:0]         cfg_wdata,
    input  logic                  cfg_commit,
    output logic                  out_valid,
    output logic [LANES*OW-1:0]   out_codes
);
    logic [EXT-1:0][LVL_W-1:0] ext;
    logic                      fresh;
    logic [TAPS-1:0][CW-1:0]   taps;
    logic [LAT-1:0]            vld_q;

    ffe_sym_hist #(.LANES(LANES), .TAPS(TAPS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mode_pam4(mode_pam4),
        .in_data  (in_data),
        .ext_o    (ext),
        .fresh_o  (fresh)
    );

    ffe_coef_bank #(.TAPS(TAPS), .CW(CW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_addr(cfg_addr),
        .wr_data(cfg_wdata),
        .commit (cfg_commit),
        .taps_o (taps)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [TAPS-1:0][LVL_W-1:0] win;
        logic                       hold;
        for (genvar j = 0; j < TAPS; j++) begin : g_tap
            assign win[j] = ext[HIST + k - j];
        end
        if (k < HIST) begin : g_edge
            assign hold = fresh;
        end else begin : g_inner
            assign hold = 1'b0;
        end
        ffe_lane #(.TAPS(TAPS), .CW(CW), .OW(OW), .SHIFT(SHIFT)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .win_i (win),
            .taps_i(taps),
            .hold_i(hold),
            .code_o(out_codes[k*OW +: OW])
        );
    end

    // Valid delay line matching the lane pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[LAT-2:0], in_valid};
        end
    end

    assign out_valid = vld_q[LAT-1];

    // R6
    lat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R6
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);
endmodule

// File: tb/ffe_tx_dp_test.sv
module ffe_tx_dp_test;
    localparam int LANES = 16, TAPS = 8, CW = 8, OW = 7, SHIFT = 3;
    localparam int HIST = TAPS - 1, AW = $clog2(TAPS);
    localparam int WW = LANES * OW;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, mode_pam4 = 1'b0;
    logic cfg_we = 1'b0, cfg_commit = 1'b0;
    logic [2*LANES-1:0] in_data = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic out_valid;
    logic [WW-1:0] out_codes;

    ffe_tx_dp #(.LANES(LANES), .TAPS(TAPS), .CW(CW), .OW(OW), .SHIFT(SHIFT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_pam4(mode_pam4),
        .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit),
        .out_valid(out_valid), .out_codes(out_codes)
    );

    always #2 clk = ~clk;

    int checks = 0, failures = 0;
    logic done = 1'b0;
    string cur_req = "R1";
    int m_hist[HIST];
    int m_act[TAPS];
    int m_shadow[TAPS];
    int tv[TAPS];
    logic m_last, m_fresh;
    logic [2:0] vh = '0;
    logic [WW-1:0] exp_q[$];
    logic [WW-1:0] last_seen = '0, prev_seen = '0;

    function automatic int lvl(input logic md, input logic [1:0] b);
        if (!md) return b[0] ? 3 : -3;
        case (b)
            2'b00:   return -3;
            2'b01:   return -1;
            2'b11:   return 1;
            default: return 3;
        endcase
    endfunction

    task automatic model_word(input logic md, input logic [2*LANES-1:0] d, output logic [WW-1:0] e);
        int cur[LANES];
        int ext[LANES+HIST];
        logic clr;
        int acc, r;
        clr = m_fresh || (md != m_last);
        for (int k = 0; k < LANES; k++) cur[k] = md ? lvl(md, d[2*k +: 2]) : lvl(md, {1'b0, d[k]});
        for (int i = 0; i < HIST; i++) ext[i] = clr ? 0 : m_hist[i];
        for (int k = 0; k < LANES; k++) ext[HIST+k] = cur[k];
        for (int k = 0; k < LANES; k++) begin
            acc = 0;
            for (int j = 0; j < TAPS; j++) acc += m_act[j] * ext[HIST+k-j];
            r = (acc + (1 << (SHIFT-1))) >>> SHIFT;
            if (r > 63) r = 63;
            if (r < -64) r = -64;
            if (clr && k < HIST) r = 0;
            e[k*OW +: OW] = OW'(r + 64);
        end
        for (int i = 0; i < HIST; i++) m_hist[i] = cur[LANES-HIST+i];
        m_last = md;
        m_fresh = 1'b0;
    endtask

    task automatic step(input logic v, input logic md, input logic [2*LANES-1:0] d,
                        input logic cm, input logic we, input logic [AW-1:0] a,
                        input logic [CW-1:0] wd);
        logic [WW-1:0] e;
        logic shown;
        @(negedge clk);
        checks++;
        if (out_valid !== vh[2]) begin
            failures++;
            $display("FAIL R6 out_valid actual %b expected %b", out_valid, vh[2]);
        end
        if (out_valid === 1'b1 && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            prev_seen = last_seen;
            last_seen = out_codes;
            checks++;
            if (out_codes !== e) begin
                failures++;
                shown = 1'b0;
                for (int k = 0; k < LANES; k++) begin
                    if (!shown && out_codes[k*OW +: OW] !== e[k*OW +: OW]) begin
                        $display("FAIL %s lane %0d actual %0d expected %0d", cur_req, k,
                                 out_codes[k*OW +: OW], e[k*OW +: OW]);
                        shown = 1'b1;
                    end
                end
            end
        end
        in_valid = v; mode_pam4 = md; in_data = d; cfg_commit = cm;
        cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        vh = {vh[1:0], v};
        if (v) begin
            model_word(md, d, e);
            exp_q.push_back(e);
        end
        if (cm) for (int j = 0; j < TAPS; j++) m_act[j] = m_shadow[j];
        if (we) m_shadow[a] = int'($signed(wd));
    endtask

    task automatic word(input logic md, input logic [2*LANES-1:0] d);
        step(1'b1, md, d, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic flush();
        repeat (4) idle();
    endtask

    task automatic load_taps();
        for (int j = 0; j < TAPS; j++) step(1'b0, 1'b0, '0, 1'b0, 1'b1, AW'(j), CW'(tv[j]));
        step(1'b0, 1'b0, '0, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic chk(input string req, input logic [WW-1:0] w, input int lane, input int expv);
        checks++;
        if (int'(w[lane*OW +: OW]) != expv) begin
            failures++;
            $display("FAIL %s lane %0d actual %0d expected %0d", req, lane, w[lane*OW +: OW], expv);
        end
    endtask

    task automatic t_reset();
        cur_req = "R8";
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R6 out_valid after reset actual %b expected 0", out_valid);
        end
        word(1'b0, 32'h0000_A5C3);
        flush();
        chk("R8", last_seen, 0, 64);
        chk("R8", last_seen, 15, 64);
    endtask

    task automatic t_nrz();
        cur_req = "R1";
        tv = '{100, 0, 0, 0, 0, 0, 0, 0};
        load_taps();
        word(1'b0, 32'h0000_A5C3);
        word(1'b0, 32'h0000_0000);
        word(1'b0, 32'h0000_FFFF);
        word(1'b0, 32'h0000_1234);
        flush();
        chk("R1", last_seen, 2, 102);
        chk("R1", last_seen, 0, 27);
    endtask

    task automatic t_pam4();
        cur_req = "R2";
        word(1'b1, 32'h1B1B_E4E4);
        word(1'b1, 32'h9C63_0F5A);
        word(1'b1, 32'h0000_001B);
        flush();
        chk("R2", last_seen, 0, 77);
        chk("R2", last_seen, 1, 102);
        chk("R2", last_seen, 2, 52);
        chk("R2", last_seen, 3, 27);
    endtask

    task automatic t_history();
        cur_req = "R3";
        tv = '{0, 0, 0, 0, 0, 0, 0, 64};
        load_taps();
        word(1'b0, 32'h0000_5555);
        word(1'b0, 32'h0000_0200);
        word(1'b0, 32'h0000_0000);
        flush();
        chk("R3", last_seen, 0, 88);
        chk("R3", last_seen, 1, 40);
        cur_req = "R10";
        word(1'b0, 32'h0000_0200);
        idle();
        idle();
        word(1'b0, 32'h0000_0000);
        flush();
        chk("R10", last_seen, 0, 88);
        chk("R10", last_seen, 1, 40);
        cur_req = "R3";
        tv = '{20, -50, 0, 64, 0, 0, -7, 30};
        load_taps();
        word(1'b0, 32'h0000_C3A5);
        word(1'b0, 32'h0000_0F0F);
        word(1'b0, 32'h0000_8001);
        idle();
        word(1'b0, 32'h0000_7E11);
        flush();
    endtask

    task automatic t_round();
        cur_req = "R4";
        tv = '{4, 0, 0, 0, 0, 0, 0, 0};
        load_taps();
        word(1'b0, 32'h0000_00FF);
        flush();
        chk("R4", last_seen, 0, 66);
        chk("R4", last_seen, 15, 63);
    endtask

    task automatic t_sat();
        cur_req = "R5";
        tv = '{127, 127, 127, 127, 127, 127, 127, 127};
        load_taps();
        word(1'b0, 32'h0000_FFFF);
        word(1'b0, 32'h0000_FFFF);
        flush();
        chk("R5", last_seen, 0, 127);
        chk("R5", last_seen, 15, 127);
        tv = '{-128, -128, -128, -128, -128, -128, -128, -128};
        load_taps();
        word(1'b0, 32'h0000_FFFF);
        word(1'b0, 32'h0000_FFFF);
        flush();
        chk("R5", last_seen, 0, 0);
        chk("R5", last_seen, 15, 0);
        word(1'b0, 32'h0000_0000);
        word(1'b0, 32'h0000_0000);
        flush();
        chk("R5", last_seen, 7, 127);
    endtask

    task automatic t_shadow();
        cur_req = "R7";
        tv = '{100, 0, 0, 0, 0, 0, 0, 0};
        load_taps();
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, '0, 8'h9C);
        word(1'b0, 32'h0000_FFFF);
        word(1'b0, 32'h0000_FFFF);
        flush();
        chk("R7", last_seen, 5, 102);
        cur_req = "R8";
        step(1'b1, 1'b0, 32'h0000_FFFF, 1'b1, 1'b0, '0, '0);
        word(1'b0, 32'h0000_FFFF);
        flush();
        chk("R8", prev_seen, 0, 102);
        chk("R8", last_seen, 0, 27);
    endtask

    task automatic t_mode();
        cur_req = "R9";
        word(1'b0, 32'h0000_FFFF);
        word(1'b1, 32'h0000_FFFF);
        word(1'b0, 32'h0000_FFFF);
        flush();
        chk("R9", prev_seen, 0, 64);
        chk("R9", prev_seen, 7, 52);
        chk("R9", last_seen, 6, 64);
        chk("R9", last_seen, 7, 27);
    endtask

    task automatic t_gaps();
        cur_req = "R6";
        word(1'b0, 32'h0000_1357);
        idle();
        word(1'b0, 32'h0000_2468);
        word(1'b0, 32'h0000_ACE1);
        idle();
        idle();
        word(1'b0, 32'h0000_BDF0);
        flush();
    endtask

    initial begin
        for (int i = 0; i < HIST; i++) m_hist[i] = 0;
        for (int j = 0; j < TAPS; j++) begin
            m_act[j] = 0;
            m_shadow[j] = 0;
        end
        m_last = 1'b0;
        m_fresh = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nrz();
        t_pam4();
        t_history();
        t_round();
        t_sat();
        t_shadow();
        t_mode();
        t_gaps();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R6 watchdog actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule